// File: doc/BRIEF.md
# Cache access statistics counter bank

This block is a bank of performance counters for one cache. It holds a two-dimensional matrix of counters, one for each pair of memory access type and access outcome. The cache presents an event strobe once per access. The strobe carries a type code and an outcome code, and the selected counter goes up by one. An event with a code outside the legal range changes no counter and raises an error flag.

A clear input zeroes the whole matrix. A merge input adds a second bank's counters into this one, element by element. A read port returns any single counter. Four summary outputs give condensed figures: the access total, misses, pending hits and reservation failures. A mask query returns the sum over a chosen set of types crossed with a chosen set of outcomes. The number of access types, the counter width and the code widths are parameters.

Top module: `cache_stat_bank`

## Requirements
- R1: After reset every counter reads zero, every summary and query sum is zero, and `ev_err_o` is low.
- R2: A legal event (`ev_valid_i` high, `ev_type_i` < NUM_TYPES, `ev_outc_i` < 4) adds exactly one to the counter at (type, outcome) on the next clock edge. No other counter changes. Outcome codes: hit=0, pending hit=1, miss=2, reservation failure=3.
- R3: `clear_i` zeroes every counter on the next edge. Clear wins over an event or a merge in the same cycle.
- R4: An event whose type code is NUM_TYPES or above, or whose outcome code is 4 or above, changes no counter. `ev_err_o` is high in the cycle after such an event and low after any other cycle.
- R5: Counters saturate at 2^CNT_W-1 and never wrap, whether they are incremented or merged.
- R6: `rd_cnt_o` shows, without a clock edge, the counter at (`rd_type_i`, `rd_outc_i`). It shows zero for an out-of-range pair.
- R7: `sum_access_o` is the sum of the hit, pending-hit and miss counters over all types. Reservation failures are not included.
- R8: `sum_miss_o`, `sum_pend_o` and `sum_rfail_o` are each the sum of that outcome's counters over all types.
- R9: `merge_valid_i` adds `merge_cnt_i` into the matrix element by element, with saturation. The counter for type t and outcome o sits at bit offset (t*4+o)*CNT_W.
- R10: A merge and a legal event in the same cycle both take effect on the target counter.
- R11: `q_sum_o` is the sum of every counter whose type t has `q_type_mask_i[t]` set and whose outcome o has `q_outc_mask_i[o]` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Zero all counters |
| ev_valid_i | input | 1 | Access event strobe |
| ev_type_i | input | TYPE_W | Access type code of the event |
| ev_outc_i | input | OUT_W | Outcome code of the event |
| ev_err_o | output | 1 | Illegal code seen in the previous cycle |
| merge_valid_i | input | 1 | Add the other bank's counters |
| merge_cnt_i | input | NUM_TYPES*4*CNT_W | Other bank's counter matrix, flattened |
| rd_type_i | input | TYPE_W | Read port type select |
| rd_outc_i | input | OUT_W | Read port outcome select |
| rd_cnt_o | output | CNT_W | Selected counter |
| q_type_mask_i | input | NUM_TYPES | Query type set |
| q_outc_mask_i | input | 4 | Query outcome set |
| q_sum_o | output | SUM_W | Query sum |
| sum_access_o | output | SUM_W | Hits, pending hits and misses, over all types |
| sum_miss_o | output | SUM_W | Misses over all types |
| sum_pend_o | output | SUM_W | Pending hits over all types |
| sum_rfail_o | output | SUM_W | Reservation failures over all types |

## Verification
The assertions assume the summaries can only fall when `clear_i` is asserted. That holds only while `merge_cnt_i` adds non-negative amounts, which is always true for unsigned counts. The "illegal event changes nothing" property covers only cycles with no clear and no merge. The stimulus therefore sends every illegal code in cycles with both controls idle. It exercises the clear-wins and merge-with-event cases in separate, marked cycles. Saturation is reached by merging preloaded values near the maximum, not by billions of increments.

// File: rtl/cstat_pkg.sv
package cstat_pkg;
  localparam int unsigned NUM_OUTC = 4;

  typedef enum logic [1:0] {
    OC_HIT   = 2'd0,
    OC_PEND  = 2'd1,
    OC_MISS  = 2'd2,
    OC_RFAIL = 2'd3
  } outc_e;

  // outcome masks used by the fixed summaries
  localparam logic [NUM_OUTC-1:0] MASK_ACCESS = 4'b0111;
  localparam logic [NUM_OUTC-1:0] MASK_PEND   = 4'b0010;
  localparam logic [NUM_OUTC-1:0] MASK_MISS   = 4'b0100;
  localparam logic [NUM_OUTC-1:0] MASK_RFAIL  = 4'b1000;
endpackage

// File: rtl/cstat_cell.sv
module cstat_cell #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] add_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W+1:0] sum_w;
  logic [CNT_W-1:0] nxt;

  always_comb begin
    sum_w = {2'b00, cnt_o} + {2'b00, add_i} + {{(CNT_W+1){1'b0}}, inc_i};
    nxt   = (sum_w[CNT_W+1:CNT_W] != 2'b00) ? {CNT_W{1'b1}} : sum_w[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (clear_i) cnt_o <= '0;
    else              cnt_o <= nxt;
  end
endmodule

// File: rtl/cstat_reduce.sv
module cstat_reduce #(
  parameter int unsigned N     = 16,
  parameter int unsigned CNT_W = 32,
  parameter int unsigned SUM_W = CNT_W + $clog2(N)
) (
  input  logic [N*CNT_W-1:0] cnt_i,
  input  logic [N-1:0]       sel_i,
  output logic [SUM_W-1:0]   sum_o
);
  always_comb begin
    sum_o = '0;
    for (int i = 0; i < N; i++) begin
      if (sel_i[i]) sum_o = sum_o + SUM_W'(cnt_i[i*CNT_W +: CNT_W]);
    end
  end
endmodule

// File: rtl/cache_stat_bank.sv
module cache_stat_bank
  import cstat_pkg::*;
#(
  parameter int unsigned NUM_TYPES = 5,
  parameter int unsigned TYPE_W    = 3,
  parameter int unsigned OUT_W     = 3,
  parameter int unsigned CNT_W     = 32,
  localparam int unsigned NCNT     = NUM_TYPES * NUM_OUTC,
  localparam int unsigned SUM_W    = CNT_W + $clog2(NCNT)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clear_i,
  input  logic                  ev_valid_i,
  input  logic [TYPE_W-1:0]     ev_type_i,
  input  logic [OUT_W-1:0]      ev_outc_i,
  output logic                  ev_err_o,
  input  logic                  merge_valid_i,
  input  logic [NCNT*CNT_W-1:0] merge_cnt_i,
  input  logic [TYPE_W-1:0]     rd_type_i,
  input  logic [OUT_W-1:0]      rd_outc_i,
  output logic [CNT_W-1:0]      rd_cnt_o,
  input  logic [NUM_TYPES-1:0]  q_type_mask_i,
  input  logic [NUM_OUTC-1:0]   q_outc_mask_i,
  output logic [SUM_W-1:0]      q_sum_o,
  output logic [SUM_W-1:0]      sum_access_o,
  output logic [SUM_W-1:0]      sum_miss_o,
  output logic [SUM_W-1:0]      sum_pend_o,
  output logic [SUM_W-1:0]      sum_rfail_o
);
  logic [NCNT*CNT_W-1:0] cnt_flat;
  logic                  ev_legal;

  assign ev_legal = ({1'b0, ev_type_i} < (TYPE_W+1)'(NUM_TYPES)) &&
                    ({1'b0, ev_outc_i} < (OUT_W+1)'(NUM_OUTC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ev_err_o <= 1'b0;
    else         ev_err_o <= ev_valid_i && !ev_legal;
  end

  // counter matrix, index t*NUM_OUTC+o
  for (genvar t = 0; t < NUM_TYPES; t++) begin : g_type
    for (genvar o = 0; o < NUM_OUTC; o++) begin : g_outc
      localparam int unsigned IDX = t * NUM_OUTC + o;
      logic             hit_ev;
      logic [CNT_W-1:0] addend;
      assign hit_ev = ev_valid_i && (ev_type_i == TYPE_W'(t)) && (ev_outc_i == OUT_W'(o));
      assign addend = merge_valid_i ? merge_cnt_i[IDX*CNT_W +: CNT_W] : '0;
      cstat_cell #(.CNT_W(CNT_W)) i_cell (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (clear_i),
        .inc_i   (hit_ev),
        .add_i   (addend),
        .cnt_o   (cnt_flat[IDX*CNT_W +: CNT_W])
      );
    end
  end

  always_comb begin
    rd_cnt_o = '0;
    for (int t = 0; t < NUM_TYPES; t++) begin
      for (int o = 0; o < NUM_OUTC; o++) begin
        if (rd_type_i == TYPE_W'(t) && rd_outc_i == OUT_W'(o))
          rd_cnt_o = cnt_flat[(t*NUM_OUTC+o)*CNT_W +: CNT_W];
      end
    end
  end

  // five reducers: user query plus the four fixed summaries
  logic [NUM_OUTC-1:0] om [5];
  logic [SUM_W-1:0]    sums [5];
  assign om[0] = q_outc_mask_i;
  assign om[1] = MASK_ACCESS;
  assign om[2] = MASK_MISS;
  assign om[3] = MASK_PEND;
  assign om[4] = MASK_RFAIL;

  for (genvar k = 0; k < 5; k++) begin : g_red
    logic [NCNT-1:0] sel;
    for (genvar t = 0; t < NUM_TYPES; t++) begin : g_st
      for (genvar o = 0; o < NUM_OUTC; o++) begin : g_so
        if (k == 0) begin : g_q
          assign sel[t*NUM_OUTC+o] = q_type_mask_i[t] & om[k][o];
        end else begin : g_f
          assign sel[t*NUM_OUTC+o] = om[k][o];
        end
      end
    end
    cstat_reduce #(.N(NCNT), .CNT_W(CNT_W), .SUM_W(SUM_W)) i_red (
      .cnt_i (cnt_flat),
      .sel_i (sel),
      .sum_o (sums[k])
    );
  end

  assign q_sum_o      = sums[0];
  assign sum_access_o = sums[1];
  assign sum_miss_o   = sums[2];
  assign sum_pend_o   = sums[3];
  assign sum_rfail_o  = sums[4];
endmodule

// File: rtl/cstat_chk.sv
module cstat_chk #(
  parameter int unsigned NUM_TYPES = 5,
  parameter int unsigned TYPE_W    = 3,
  parameter int unsigned OUT_W     = 3,
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned SUM_W     = 37
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clear_i,
  input logic              ev_valid_i,
  input logic [TYPE_W-1:0] ev_type_i,
  input logic [OUT_W-1:0]  ev_outc_i,
  input logic              merge_valid_i,
  input logic              ev_err_o,
  input logic [TYPE_W-1:0] rd_type_i,
  input logic [CNT_W-1:0]  rd_cnt_o,
  input logic [SUM_W-1:0]  sum_access_o,
  input logic [SUM_W-1:0]  sum_miss_o,
  input logic [SUM_W-1:0]  sum_pend_o,
  input logic [SUM_W-1:0]  sum_rfail_o
);
  logic illegal;
  assign illegal = ev_valid_i &&
    !(({1'b0, ev_type_i} < (TYPE_W+1)'(NUM_TYPES)) && ({1'b0, ev_outc_i} < (OUT_W+1)'(4)));

  // R3
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (sum_access_o == '0 && sum_rfail_o == '0));

  // R4
  err_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal |=> ev_err_o);

  // R4
  err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !illegal |=> !ev_err_o);

  // R4
  illegal_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (illegal && !merge_valid_i && !clear_i) |=>
      ($stable(sum_access_o) && $stable(sum_miss_o) && $stable(sum_pend_o) && $stable(sum_rfail_o)));

  // R5
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> (sum_access_o >= $past(sum_access_o) && sum_rfail_o >= $past(sum_rfail_o)));

  // R6
  rd_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, rd_type_i} >= (TYPE_W+1)'(NUM_TYPES)) |-> (rd_cnt_o == '0));

  // R7
  access_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_access_o >= sum_miss_o && sum_access_o >= sum_pend_o);
endmodule

bind cache_stat_bank cstat_chk #(
  .NUM_TYPES (NUM_TYPES),
  .TYPE_W    (TYPE_W),
  .OUT_W     (OUT_W),
  .CNT_W     (CNT_W),
  .SUM_W     (SUM_W)
) i_cstat_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .clear_i       (clear_i),
  .ev_valid_i    (ev_valid_i),
  .ev_type_i     (ev_type_i),
  .ev_outc_i     (ev_outc_i),
  .merge_valid_i (merge_valid_i),
  .ev_err_o      (ev_err_o),
  .rd_type_i     (rd_type_i),
  .rd_cnt_o      (rd_cnt_o),
  .sum_access_o  (sum_access_o),
  .sum_miss_o    (sum_miss_o),
  .sum_pend_o    (sum_pend_o),
  .sum_rfail_o   (sum_rfail_o)
);

// File: tb/test_cache_stat_bank.sv
module test_cache_stat_bank;
  localparam int NT = 5, TW = 3, OW = 3, CW = 32, NO = 4;
  localparam int NC = NT * NO;
  localparam int SW = CW + $clog2(NC);
  localparam longint MAXV = 64'hFFFF_FFFF;

  logic clk = 0, rst_ni = 0;
  logic clear_i = 0, ev_valid_i = 0, merge_valid_i = 0;
  logic [TW-1:0] ev_type_i = '0, rd_type_i = '0;
  logic [OW-1:0] ev_outc_i = '0, rd_outc_i = '0;
  logic [NC*CW-1:0] merge_cnt_i = '0;
  logic [NT-1:0] q_type_mask_i = '0;
  logic [NO-1:0] q_outc_mask_i = '0;
  logic ev_err_o;
  logic [CW-1:0] rd_cnt_o;
  logic [SW-1:0] q_sum_o, sum_access_o, sum_miss_o, sum_pend_o, sum_rfail_o;

  int total = 0, bad = 0;
  longint expv [NT][NO];
  longint mv [NT][NO];

  always #2 clk = ~clk;

  cache_stat_bank #(.NUM_TYPES(NT), .TYPE_W(TW), .OUT_W(OW), .CNT_W(CW)) i_cache_stat_bank (
    .clk_i(clk), .rst_ni(rst_ni), .clear_i(clear_i),
    .ev_valid_i(ev_valid_i), .ev_type_i(ev_type_i), .ev_outc_i(ev_outc_i), .ev_err_o(ev_err_o),
    .merge_valid_i(merge_valid_i), .merge_cnt_i(merge_cnt_i),
    .rd_type_i(rd_type_i), .rd_outc_i(rd_outc_i), .rd_cnt_o(rd_cnt_o),
    .q_type_mask_i(q_type_mask_i), .q_outc_mask_i(q_outc_mask_i), .q_sum_o(q_sum_o),
    .sum_access_o(sum_access_o), .sum_miss_o(sum_miss_o),
    .sum_pend_o(sum_pend_o), .sum_rfail_o(sum_rfail_o));

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, update model, sample at next negedge
  task automatic step(input bit ev, input int t, input int o, input bit clr, input bit mrg);
    bit illeg;
    ev_valid_i = ev; ev_type_i = TW'(t); ev_outc_i = OW'(o);
    clear_i = clr; merge_valid_i = mrg;
    for (int a = 0; a < NT; a++)
      for (int b = 0; b < NO; b++)
        merge_cnt_i[(a*NO+b)*CW +: CW] = CW'(mv[a][b]);
    @(negedge clk);
    illeg = ev && (t >= NT || o >= NO);
    for (int a = 0; a < NT; a++)
      for (int b = 0; b < NO; b++) begin
        longint v;
        if (clr) v = 0;
        else begin
          v = expv[a][b] + (mrg ? mv[a][b] : 0) + ((ev && a == t && b == o) ? 1 : 0);
          if (v > MAXV) v = MAXV;
        end
        expv[a][b] = v;
      end
    chk("R4 ev_err_o", longint'(ev_err_o), illeg ? 1 : 0);
    ev_valid_i = 0; clear_i = 0; merge_valid_i = 0;
  endtask

  task automatic check_all(input string tag);
    longint s_acc, s_m, s_p, s_r;
    s_acc = 0; s_m = 0; s_p = 0; s_r = 0;
    for (int t = 0; t < 8; t++)
      for (int o = 0; o < 8; o++) begin
        rd_type_i = TW'(t); rd_outc_i = OW'(o); #1;
        chk({tag, " R2 R6 rd_cnt_o"}, longint'(rd_cnt_o), (t < NT && o < NO) ? expv[t][o] : 0);
      end
    for (int t = 0; t < NT; t++) begin
      s_acc += expv[t][0] + expv[t][1] + expv[t][2];
      s_p += expv[t][1]; s_m += expv[t][2]; s_r += expv[t][3];
    end
    chk({tag, " R7 access"}, longint'(sum_access_o), s_acc);
    chk({tag, " R8 miss"}, longint'(sum_miss_o), s_m);
    chk({tag, " R8 pend"}, longint'(sum_pend_o), s_p);
    chk({tag, " R8 rfail"}, longint'(sum_rfail_o), s_r);
    for (int tm = 0; tm < (1 << NT); tm++)
      for (int om = 0; om < (1 << NO); om++) begin
        longint e = 0;
        q_type_mask_i = NT'(tm); q_outc_mask_i = NO'(om); #1;
        for (int t = 0; t < NT; t++)
          for (int o = 0; o < NO; o++)
            if (tm[t] && om[o]) e += expv[t][o];
        chk({tag, " R11 q_sum"}, longint'(q_sum_o), e);
      end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int t = 0; t < NT; t++) for (int o = 0; o < NO; o++) begin expv[t][o] = 0; mv[t][o] = 0; end
    repeat (2) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk("R1 ev_err_o", longint'(ev_err_o), 0);
    check_all("R1 reset");

    // R2: distinct count per pair, illegal codes interleaved (R4)
    for (int t = 0; t < NT; t++)
      for (int o = 0; o < NO; o++)
        for (int n = 0; n <= (t * 3 + o) % 5; n++) step(1, t, o, 0, 0);
    step(1, 5, 0, 0, 0);
    step(1, 7, 2, 0, 0);
    step(1, 1, 4, 0, 0);
    step(1, 0, 7, 0, 0);
    step(0, 6, 6, 0, 0);
    check_all("R2 R4 events");

    // R9 merge, R10 merge plus event
    for (int t = 0; t < NT; t++) for (int o = 0; o < NO; o++) mv[t][o] = 100 * t + 7 * o + 1;
    step(0, 0, 0, 0, 1);
    step(1, 3, 2, 0, 1);
    check_all("R9 R10 merge");

    // R5 saturation by preload then increments and large merges
    for (int t = 0; t < NT; t++) for (int o = 0; o < NO; o++) mv[t][o] = 0;
    mv[2][1] = MAXV - 1 - expv[2][1];
    step(0, 0, 0, 0, 1);
    step(1, 2, 1, 0, 0);
    step(1, 2, 1, 0, 0);
    step(1, 2, 1, 0, 0);
    for (int t = 0; t < NT; t++) mv[t][3] = MAXV;
    step(1, 4, 3, 0, 1);
    step(0, 0, 0, 0, 1);
    check_all("R5 saturate");

    // R3 clear wins over event and merge
    step(1, 1, 1, 1, 1);
    check_all("R3 clear");
    for (int t = 0; t < NT; t++) for (int o = 0; o < NO; o++) mv[t][o] = 0;
    step(1, 4, 0, 0, 0);
    step(1, 0, 3, 0, 0);
    check_all("R2 after clear");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule